// File: doc/BRIEF.md
# Tournament Conditional Branch Predictor

This block guesses whether a conditional branch will be taken. It keeps two direction predictors side by side. The global side is gshare-style: a table of two-bit counters indexed by the lookup PC XORed with a shift register of recent branch outcomes. The local side keeps a short outcome history for each PC slot, and that history indexes a table of three-bit counters. A third table of two-bit counters, indexed the same way as the global table, learns which side has been right more often for that PC/history mix, and its verdict picks the final answer. Branches flagged as non-conditional bypass the tables and are always reported taken.

Lookup is purely combinational on the current state. Resolved outcomes come back through a separate update port, one per clock. At the next clock edge the update trains all three tables and shifts the outcome into both histories. A lookup in the same cycle as an update therefore sees the state from before that update. The histories are trained only when branches resolve; there is no speculative history.

Top module: `tourney_pred`

## Requirements
- R1: After reset the global history and every local history are zero, every global counter is 1, every local counter is 3 and every chooser counter is 2, so each conditional lookup predicts not-taken.
- R2: When `lookCond` is 0 the prediction is taken (1), whatever the table contents.
- R3: The global counter for a PC is selected by `pc ^ globalHistory`, with history width equal to `PC_W`. It is a two-bit saturating counter that predicts taken when its bit 1 is set. An update increments it when the outcome is taken and decrements it otherwise.
- R4: The local history for a PC is selected by the low `LT_IDX_W` bits of the PC. That `LH_W`-bit history selects a three-bit saturating counter that predicts taken when its bit 2 is set. An update increments it when the outcome is taken and decrements it otherwise.
- R5: The chooser counter uses the same index as the global counter. When its bit 1 is set the final prediction of a conditional branch is the global component's; otherwise it is the local component's.
- R6: On update, the chooser counter changes only if the two components disagreed. It increments (saturating at 3) when the global side was right and decrements (saturating at 0) when the local side was right.
- R7: On update, the resolved outcome is shifted into bit 0 of the global history and into bit 0 of that PC's local history; the oldest bit is dropped.
- R8: All counters saturate: an increment at the maximum and a decrement at zero leave the value unchanged.
- R9: When `updValid` is 0, no table and no history changes, whatever `updPc` and `updTaken` carry.
- R10: A lookup in the same cycle as an update returns the prediction from the state before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookPc | input | PC_W | PC of the branch being predicted |
| lookCond | input | 1 | 1 if the branch is conditional |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| updValid | input | 1 | Resolved conditional branch presented this cycle |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench carries its own model of the three tables and both histories, built from the requirements. It compares the prediction for every PC at reset, then before each update of several outcome streams: always-taken, alternating, a period-three loop, and a pseudo-random mix across all PCs. Long runs of the same outcome drive counters into saturation. A design whose counters wrapped would flip its prediction after the fourth or eighth repeat. A chooser trained on agreement would drift toward one side and mispredict patterns the other side had learned. Idle cycles with noisy update inputs would expose a design that trains without `updValid`, because its later predictions would depart from the model. Comparing before each update also checks that the lookup sees pre-update state.

// File: rtl/tourney_pkg.sv
package tourney_pkg;
  // training strobes from control to datapath
  typedef struct packed {
    logic incGlob;
    logic decGlob;
    logic incLoc;
    logic decLoc;
    logic incCh;
    logic decCh;
    logic shift;
  } trainStrb_t;
endpackage

// File: rtl/tourney_dp.sv
module tourney_dp
  import tourney_pkg::*;
#(
  parameter int PC_W     = 6,
  parameter int LT_IDX_W = 3,
  parameter int LH_W     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookPc,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  trainStrb_t      strb,
  output logic            lookGlob,
  output logic            lookLoc,
  output logic            lookUseGlob,
  output logic            updGlob,
  output logic            updLoc
);
  localparam int GSIZE  = 1 << PC_W;
  localparam int LSIZE  = 1 << LH_W;
  localparam int LTSIZE = 1 << LT_IDX_W;

  logic [PC_W-1:0] ghist;
  logic [1:0]      gTable  [GSIZE];
  logic [1:0]      chTable [GSIZE];
  logic [2:0]      lCtr    [LSIZE];
  logic [LH_W-1:0] lhist   [LTSIZE];

  logic [PC_W-1:0]     lookIdx, updIdx;
  logic [LT_IDX_W-1:0] lookSlot, updSlot;
  logic [LH_W-1:0]     lookLh, updLh;

  always_comb begin
    lookIdx     = lookPc ^ ghist;
    updIdx      = updPc ^ ghist;
    lookSlot    = lookPc[LT_IDX_W-1:0];
    updSlot     = updPc[LT_IDX_W-1:0];
    lookLh      = lhist[lookSlot];
    updLh       = lhist[updSlot];
    lookGlob    = gTable[lookIdx][1];
    lookLoc     = lCtr[lookLh][2];
    lookUseGlob = chTable[lookIdx][1];
    updGlob     = gTable[updIdx][1];
    updLoc      = lCtr[updLh][2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ghist <= '0;
      for (int i = 0; i < GSIZE; i++) begin
        gTable[i]  <= 2'd1;
        chTable[i] <= 2'd2;
      end
      for (int i = 0; i < LSIZE; i++) lCtr[i] <= 3'd3;
      for (int i = 0; i < LTSIZE; i++) lhist[i] <= '0;
    end else begin
      if (strb.incGlob && gTable[updIdx] != 2'd3) gTable[updIdx] <= gTable[updIdx] + 2'd1;
      if (strb.decGlob && gTable[updIdx] != 2'd0) gTable[updIdx] <= gTable[updIdx] - 2'd1;
      if (strb.incLoc && lCtr[updLh] != 3'd7) lCtr[updLh] <= lCtr[updLh] + 3'd1;
      if (strb.decLoc && lCtr[updLh] != 3'd0) lCtr[updLh] <= lCtr[updLh] - 3'd1;
      if (strb.incCh && chTable[updIdx] != 2'd3) chTable[updIdx] <= chTable[updIdx] + 2'd1;
      if (strb.decCh && chTable[updIdx] != 2'd0) chTable[updIdx] <= chTable[updIdx] - 2'd1;
      if (strb.shift) begin
        ghist          <= {ghist[PC_W-2:0], updTaken};
        lhist[updSlot] <= {updLh[LH_W-2:0], updTaken};
      end
    end
  end

  // R6
  choose_disagree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCh || strb.decCh) |-> (updGlob != updLoc));

  // R9
  idle_hist_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(ghist));

  // R7
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> ghist[0] == $past(updTaken));

  // R8
  glob_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incGlob && gTable[updIdx] == 2'd3) |=> gTable[$past(updIdx)] == 2'd3);

  // R8
  loc_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decLoc && lCtr[updLh] == 3'd0) |=> lCtr[$past(updLh)] == 3'd0);
endmodule

// File: rtl/tourney_ctl.sv
module tourney_ctl
  import tourney_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updGlob,
  input  logic       updLoc,
  input  logic       lookCond,
  input  logic       lookGlob,
  input  logic       lookLoc,
  input  logic       lookUseGlob,
  output trainStrb_t strb,
  output logic       predTaken
);
  logic disagree;

  always_comb begin
    disagree     = updGlob ^ updLoc;
    strb.incGlob = updValid & updTaken;
    strb.decGlob = updValid & ~updTaken;
    strb.incLoc  = updValid & updTaken;
    strb.decLoc  = updValid & ~updTaken;
    strb.incCh   = updValid & disagree & (updGlob == updTaken);
    strb.decCh   = updValid & disagree & (updLoc == updTaken);
    strb.shift   = updValid;
    if (!lookCond)        predTaken = 1'b1;
    else if (lookUseGlob) predTaken = lookGlob;
    else                  predTaken = lookLoc;
  end

  // R2
  noncond_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookCond |-> predTaken);

  // R3
  glob_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.incGlob, strb.decGlob}));

  // R6
  choose_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.incCh, strb.decCh}));
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tourney_pkg::*;
#(
  parameter int PC_W     = 6,
  parameter int LT_IDX_W = 3,
  parameter int LH_W     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookPc,
  input  logic            lookCond,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);
  trainStrb_t strb;
  logic lookGlob, lookLoc, lookUseGlob, updGlob, updLoc;

  tourney_dp #(.PC_W(PC_W), .LT_IDX_W(LT_IDX_W), .LH_W(LH_W)) dp (
    .clk(clk), .rstN(rstN), .lookPc(lookPc), .updPc(updPc), .updTaken(updTaken),
    .strb(strb), .lookGlob(lookGlob), .lookLoc(lookLoc), .lookUseGlob(lookUseGlob),
    .updGlob(updGlob), .updLoc(updLoc));

  tourney_ctl ctl (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updTaken(updTaken),
    .updGlob(updGlob), .updLoc(updLoc), .lookCond(lookCond), .lookGlob(lookGlob),
    .lookLoc(lookLoc), .lookUseGlob(lookUseGlob), .strb(strb), .predTaken(predTaken));
endmodule

// File: tb/tourney_pred_test.sv
module tourney_pred_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 6, LT_IDX_W = 3, LH_W = 4;
  localparam int GSIZE = 1 << PC_W, LSIZE = 1 << LH_W, LTSIZE = 1 << LT_IDX_W;

  logic clk = 0, rstN = 0;
  logic [PC_W-1:0] lookPc = '0, updPc = '0;
  logic lookCond = 1, updValid = 0, updTaken = 0;
  logic predTaken;

  int checks = 0, fails = 0;

  // bench model
  int mGlob [GSIZE];
  int mCh   [GSIZE];
  int mLoc  [LSIZE];
  int mLht  [LTSIZE];
  int mGh;

  tourney_pred #(.PC_W(PC_W), .LT_IDX_W(LT_IDX_W), .LH_W(LH_W)) uut (
    .clk(clk), .rstN(rstN), .lookPc(lookPc), .lookCond(lookCond), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int modelPred(int pc, bit cond);
    int gi, lh;
    if (!cond) return 1;
    gi = (pc ^ mGh) % GSIZE;
    lh = mLht[pc % LTSIZE];
    if (mCh[gi] >= 2) return (mGlob[gi] >= 2) ? 1 : 0;
    return (mLoc[lh] >= 4) ? 1 : 0;
  endfunction

  task automatic modelUpd(int pc, int t);
    int gi, lh, gp, lp;
    gi = (pc ^ mGh) % GSIZE;
    lh = mLht[pc % LTSIZE];
    gp = (mGlob[gi] >= 2);
    lp = (mLoc[lh] >= 4);
    if (t != 0) begin
      if (mGlob[gi] < 3) mGlob[gi]++;
      if (mLoc[lh] < 7) mLoc[lh]++;
    end else begin
      if (mGlob[gi] > 0) mGlob[gi]--;
      if (mLoc[lh] > 0) mLoc[lh]--;
    end
    if (gp != lp) begin
      if (gp == t) begin if (mCh[gi] < 3) mCh[gi]++; end
      else begin if (mCh[gi] > 0) mCh[gi]--; end
    end
    mGh = ((mGh << 1) | t) % GSIZE;
    mLht[pc % LTSIZE] = ((lh << 1) | t) % LSIZE;
  endtask

  task automatic check(string tag, int pc, bit cond);
    int exp;
    exp = modelPred(pc, cond);
    checks++;
    if (predTaken !== exp[0]) begin
      fails++;
      $display("FAIL %s pc=%0d cond=%0d got=%0b exp=%0d", tag, pc, cond, predTaken, exp);
    end
  endtask

  // present a lookup and an update for the same PC in one cycle (R10)
  task automatic step(string tag, int pc, int t);
    @(negedge clk);
    lookPc = pc[PC_W-1:0]; lookCond = 1;
    updValid = 1; updPc = pc[PC_W-1:0]; updTaken = t[0];
    #1 check(tag, pc, 1);
    modelUpd(pc, t);
  endtask

  task automatic sweep(string tag);
    @(negedge clk);
    updValid = 0;
    for (int p = 0; p < GSIZE; p++) begin
      lookPc = p[PC_W-1:0];
      lookCond = 1; #1 check(tag, p, 1);
      lookCond = 0; #1 check(tag, p, 0);
    end
  endtask

  initial begin
    int seed;
    for (int i = 0; i < GSIZE; i++) begin mGlob[i] = 1; mCh[i] = 2; end
    for (int i = 0; i < LSIZE; i++) mLoc[i] = 3;
    for (int i = 0; i < LTSIZE; i++) mLht[i] = 0;
    mGh = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1, R2: reset state for every PC, both branch types
    sweep("R1/R2 reset");

    // R3, R8: always taken on one PC, into saturation
    for (int i = 0; i < 20; i++) step("R3/R8 taken run", 5, 1);
    // R4, R8: long not-taken run drives local counters to zero
    for (int i = 0; i < 20; i++) step("R4/R8 not-taken run", 5, 0);
    // R5, R6: alternating outcomes make the components disagree
    for (int i = 0; i < 40; i++) step("R5/R6 alternating", 12, i % 2);
    // R4, R7: period-three loop branch
    for (int i = 0; i < 60; i++) step("R4/R7 loop", 3, (i % 3 != 2) ? 1 : 0);

    // R9: idle cycles with noisy update inputs
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      updValid = 0; updPc = i[PC_W-1:0]; updTaken = i[0];
    end
    sweep("R9 idle");

    // R3/R5/R6/R7: pseudo-random mix across all PCs
    seed = 7;
    for (int i = 0; i < 2000; i++) begin
      int pc, t;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      pc = (seed >> 8) % GSIZE;
      t = ((seed >> 4) % 4 != 0) ? (pc % 2) : 1 - (pc % 2);
      step("R3/R5/R6/R7 mix", pc, t);
    end
    sweep("R2/R5 final");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule